// File: doc/BRIEF.md
# Flash Sector Erase Sequencer

This block takes a host request naming a first and a last sector index and erases that range on an 8-bit parallel NOR-style flash through a simple strobed command bus. Sectors are 128 KiB apart, starting at a configurable device base address. A per-sector protect bitmap marks sectors that must be left alone; those are stepped over and counted. For every other sector the block writes the clear-status, erase-setup and confirm command bytes at the sector base, waits a minimum settling time, polls the status byte until its ready bit is set, and then returns the device to read-array mode before it moves to the next sector.

A single operation timer runs from the moment a request is accepted. If a status poll comes back not ready after that timer has reached its limit, the block suspends the erase, puts the device back into read-array mode and ends the operation with an error. Malformed ranges are refused at once, with no bus traffic. The host sees a busy level, a one-cycle done pulse, an error flag and the number of protected sectors skipped, the last two held until the next accepted request.

Top module: `flash_erase_seq`

## Requirements
- R1: A request with a negative first index, a first index greater than the last, or a last index of NUM_SECT or more is refused: done pulses in the cycle after the request with error=1 and skip_cnt=0, and no bus access is made.
- R2: A sector whose protect bit (protect[i] for sector i) is 1 receives no bus access; at done, skip_cnt equals the number of protected sectors visited in the range.
- R3: Each unprotected sector is erased by three writes at address DEV_BASE + i*0x20000, data 0x50, then 0x20, then 0xD0.
- R4: Sectors are handled in ascending index order from the first to the last index.
- R5: No status read of a sector is issued until more than PRE_POLL_CYC cycles after its 0xD0 write strobe.
- R6: Status reads at the sector base repeat until a read returns bit 7 set; the block then writes 0xFF at that base and goes on to the next sector.
- R7: When a status read returns bit 7 clear and at least TIMEOUT_CYC cycles have passed since the request was accepted, the block writes 0xB0 then 0xFF at that sector base, touches no further sector and ends with error=1.
- R8: After the last sector succeeds, done pulses for one cycle with error=0; busy is 1 from the cycle after acceptance until done and 0 in idle.
- R9: Every bus access is a one-cycle strobe on either fl_we or fl_re, never both, followed by BUS_WAIT wait cycles before the next strobe; read data is taken at the end of the last wait cycle.
- R10: A request presented while an operation is running is ignored and does not change the access sequence or the reported result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe, taken only when idle |
| req_first | input | SIW (8) | First sector index, signed |
| req_last | input | SIW (8) | Last sector index, signed |
| protect | input | NUM_SECT (128) | Protect bitmap, held stable while busy |
| busy | output | 1 | Operation running |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Result of the last operation, valid from done |
| skip_cnt | output | SIW (8) | Protected sectors skipped in the last operation |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | ADDR_W (32) | Flash byte address, held during an access |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data |

## Verification
A refused request must raise done exactly one cycle after the request is taken, so the bench drives the request on a falling edge and samples done, error and skip_cnt on the next falling edge, then confirms done has dropped one cycle later. Accepted operations have a data-dependent length, so the bench predicts the ordered list of command writes, queues it before the request, and a monitor sampling on falling edges pops and compares every write strobe as it appears, while counting cycles between strobes and since each confirm write to check the access spacing and the pre-poll wait. Busy is checked one cycle after acceptance, and result fields are checked on the falling edge where done is seen, together with an empty expectation queue.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SCAN, ST_CLR, ST_SETUP, ST_CONF, ST_DLY,
    ST_POLL, ST_RDARR, ST_SUSP, ST_ABRD, ST_FIN
  } fes_state_e;

  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
  localparam int unsigned RDY_BIT     = 7;
endpackage

// File: rtl/fes_cnt.sv
module fes_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;
  logic         q_en;

  always_comb begin
    q_en = clr | (en & ~(&q));
    q_n  = clr ? '0 : q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_n;
  end
endmodule

// File: rtl/fes_bus.sv
module fes_bus #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned WAIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_wr,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [7:0]        go_data,
  output logic              fl_we,
  output logic              fl_re,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  input  logic [7:0]        fl_rdata,
  output logic              ack,
  output logic [7:0]        ack_data
);
  localparam int unsigned CW = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;

  logic          strobe_q, wr_q, act_q, act_n, load, sample;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    load   = go & ~act_q;
    sample = act_q & (cnt_q == '0);
    act_n  = act_q;
    cnt_n  = cnt_q;
    if (load) begin
      act_n = 1'b1;
      cnt_n = CW'(WAIT_CYC);
    end else if (act_q) begin
      if (cnt_q == '0) act_n = 1'b0;
      else             cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      act_q    <= 1'b0;
      cnt_q    <= '0;
      ack      <= 1'b0;
    end else begin
      strobe_q <= load;
      act_q    <= act_n;
      cnt_q    <= cnt_n;
      ack      <= sample;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      fl_addr  <= '0;
      fl_wdata <= '0;
    end else if (load) begin
      wr_q     <= go_wr;
      fl_addr  <= go_addr;
      fl_wdata <= go_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ack_data <= '0;
    else if (sample) ack_data <= fl_rdata;
  end

  assign fl_we = strobe_q & wr_q;
  assign fl_re = strobe_q & ~wr_q;

  // R9: only one access in flight
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !act_q);
  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we || fl_re) |=> !(fl_we || fl_re));
  a_r9_we_re_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !load && $past(act_q)) |-> $stable(fl_addr));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int unsigned NUM_SECT     = 128,
  parameter int unsigned ADDR_W       = 32,
  parameter logic [31:0] DEV_BASE     = 32'h0000_0000,
  parameter int unsigned SECT_SHIFT   = 17,
  parameter int unsigned PRE_POLL_CYC = 100000,
  parameter int unsigned TIMEOUT_CYC  = 100000000,
  parameter int unsigned BUS_WAIT     = 2,
  localparam int unsigned IDX_W       = $clog2(NUM_SECT),
  localparam int unsigned SIW         = IDX_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic signed [SIW-1:0] req_first,
  input  logic signed [SIW-1:0] req_last,
  input  logic [NUM_SECT-1:0]   protect,
  output logic                  busy,
  output logic                  done,
  output logic                  error,
  output logic [SIW-1:0]        skip_cnt,
  output logic                  fl_we,
  output logic                  fl_re,
  output logic [ADDR_W-1:0]     fl_addr,
  output logic [7:0]            fl_wdata,
  input  logic [7:0]            fl_rdata
);
  localparam int unsigned PW = $clog2(PRE_POLL_CYC + 2);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 2);
  localparam logic [PW-1:0] PRE_LIM = PW'(PRE_POLL_CYC);
  localparam logic [TW-1:0] TO_LIM  = TW'(TIMEOUT_CYC);
  localparam logic signed [SIW:0] IDX_LIM = (SIW+1)'(NUM_SECT);

  fes_state_e       st_q, st_n;
  logic [IDX_W-1:0] cur_q, cur_n, last_q, last_n;
  logic [SIW-1:0]   skip_n;
  logic             err_n, issued_q, issued_n;
  logic             go, go_wr, ack;
  logic [7:0]       go_data, ack_data;
  logic [ADDR_W-1:0] sect_base;
  logic             op_clr, dly_clr, dly_en, accept, bad_req, at_last;
  logic [PW-1:0]    dly_q;
  logic [TW-1:0]    op_q;
  logic signed [SIW:0] f_ext, l_ext;

  always_comb begin
    f_ext   = {req_first[SIW-1], req_first};
    l_ext   = {req_last[SIW-1], req_last};
    bad_req = f_ext[SIW] | (f_ext > l_ext) | (l_ext >= IDX_LIM);
    accept  = (st_q == ST_IDLE) & req_valid;
    at_last = (cur_q == last_q);
    sect_base = ADDR_W'(DEV_BASE) + (ADDR_W'(cur_q) << SECT_SHIFT);
  end

  // bus-issuing states and their command bytes
  always_comb begin
    go      = 1'b0;
    go_wr   = 1'b1;
    go_data = CMD_RD_ARRAY;
    unique case (st_q)
      ST_CLR:   begin go = ~issued_q; go_data = CMD_CLR_STAT; end
      ST_SETUP: begin go = ~issued_q; go_data = CMD_ERASE;    end
      ST_CONF:  begin go = ~issued_q; go_data = CMD_CONFIRM;  end
      ST_POLL:  begin go = ~issued_q; go_wr   = 1'b0;         end
      ST_RDARR: begin go = ~issued_q; go_data = CMD_RD_ARRAY; end
      ST_SUSP:  begin go = ~issued_q; go_data = CMD_SUSPEND;  end
      ST_ABRD:  begin go = ~issued_q; go_data = CMD_RD_ARRAY; end
      default:  ;
    endcase
  end

  // next-state logic
  always_comb begin
    st_n     = st_q;
    cur_n    = cur_q;
    last_n   = last_q;
    skip_n   = skip_cnt;
    err_n    = error;
    issued_n = issued_q;
    dly_clr  = 1'b0;
    dly_en   = 1'b0;
    op_clr   = accept;
    if (go)  issued_n = 1'b1;
    if (ack) issued_n = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        skip_n = '0;
        if (bad_req) begin
          err_n = 1'b1;
          st_n  = ST_FIN;
        end else begin
          err_n  = 1'b0;
          cur_n  = req_first[IDX_W-1:0];
          last_n = req_last[IDX_W-1:0];
          st_n   = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (protect[cur_q]) begin
          skip_n = skip_cnt + 1'b1;
          if (at_last) st_n = ST_FIN;
          else         cur_n = cur_q + 1'b1;
        end else begin
          st_n = ST_CLR;
        end
      end
      ST_CLR:   if (ack) st_n = ST_SETUP;
      ST_SETUP: if (ack) st_n = ST_CONF;
      ST_CONF:  if (ack) begin
        st_n    = ST_DLY;
        dly_clr = 1'b1;
      end
      ST_DLY: begin
        dly_en = 1'b1;
        if (dly_q >= PRE_LIM) st_n = ST_POLL;
      end
      ST_POLL: if (ack) begin
        if (ack_data[RDY_BIT]) st_n = ST_RDARR;
        else if (op_q >= TO_LIM) st_n = ST_SUSP;
      end
      ST_RDARR: if (ack) begin
        if (at_last) st_n = ST_FIN;
        else begin
          cur_n = cur_q + 1'b1;
          st_n  = ST_SCAN;
        end
      end
      ST_SUSP: if (ack) st_n = ST_ABRD;
      ST_ABRD: if (ack) begin
        err_n = 1'b1;
        st_n  = ST_FIN;
      end
      ST_FIN:  st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cur_q    <= '0;
      last_q   <= '0;
      skip_cnt <= '0;
      error    <= 1'b0;
      issued_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      cur_q    <= cur_n;
      last_q   <= last_n;
      skip_cnt <= skip_n;
      error    <= err_n;
      issued_q <= issued_n;
    end
  end

  assign busy = (st_q != ST_IDLE) && (st_q != ST_FIN);
  assign done = (st_q == ST_FIN);

  fes_cnt #(.W(TW)) u_op_tmr (
    .clk(clk), .rst_n(rst_n), .clr(op_clr), .en(busy), .q(op_q)
  );

  fes_cnt #(.W(PW)) u_dly_tmr (
    .clk(clk), .rst_n(rst_n), .clr(dly_clr), .en(dly_en), .q(dly_q)
  );

  fes_bus #(.ADDR_W(ADDR_W), .WAIT_CYC(BUS_WAIT)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .go(go), .go_wr(go_wr), .go_addr(sect_base), .go_data(go_data),
    .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata), .ack(ack), .ack_data(ack_data)
  );

  // R1: refused request ends at once with error
  a_r1_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bad_req) |=> (done && error && skip_cnt == '0));
  // R5: no poll before the settling wait
  a_r5_poll_gap: assert property (@(posedge clk) disable iff (!rst_n)
    fl_re |-> (dly_q >= PRE_LIM));
  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: bus quiet outside an operation
  a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(fl_we || fl_re));
  // R2: skip count within range size
  a_r2_skip_bound: assert property (@(posedge clk) disable iff (!rst_n)
    skip_cnt <= SIW'(NUM_SECT));
  // R10: a running operation holds its range
  a_r10_range_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(last_q));
endmodule

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
  localparam int unsigned NS   = 128;
  localparam int unsigned SIW  = 8;
  localparam int unsigned PRE  = 8;
  localparam int unsigned TOUT = 600;
  localparam int unsigned BW   = 1;
  localparam logic [31:0] BASE = 32'h0400_0000;

  logic clk, rst_n, req_valid;
  logic signed [SIW-1:0] req_first, req_last;
  logic [NS-1:0] protect;
  logic busy, done, error, fl_we, fl_re;
  logic [SIW-1:0] skip_cnt;
  logic [31:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;

  int checks = 0, fails = 0;
  int cyc = 0, last_strobe = -1000, conf_cyc = 0, reads = 0, ready_after = 1;
  logic [31:0] cur_base = '0;
  logic [7:0] last_wr = '0;
  logic [39:0] exp_q[$];

  flash_erase_seq #(
    .NUM_SECT(NS), .ADDR_W(32), .DEV_BASE(BASE), .SECT_SHIFT(17),
    .PRE_POLL_CYC(PRE), .TIMEOUT_CYC(TOUT), .BUS_WAIT(BW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_first(req_first),
    .req_last(req_last), .protect(protect), .busy(busy), .done(done),
    .error(error), .skip_cnt(skip_cnt), .fl_we(fl_we), .fl_re(fl_re),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // monitor and flash model, sampled on falling edges
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (fl_we || fl_re) begin
        chk(!(fl_we && fl_re), "R9 strobe exclusive", {fl_we, fl_re}, 2);
        chk(cyc - last_strobe >= 1 + BW, "R9 strobe spacing", cyc - last_strobe, 1 + BW);
        last_strobe = cyc;
      end
      if (fl_we) begin
        if (exp_q.size() == 0) begin
          chk(0, "R2/R7 unexpected write", {fl_addr, fl_wdata}, 0);
        end else begin
          logic [39:0] e;
          e = exp_q.pop_front();
          chk({fl_addr, fl_wdata} == e, "R3/R4 write sequence", {fl_addr, fl_wdata}, e);
        end
        if (fl_wdata == 8'hD0) begin
          reads = 0;
          conf_cyc = cyc;
        end
        if (fl_wdata == 8'hFF && last_wr == 8'hD0)
          chk(reads == ready_after, "R6 poll count", reads, ready_after);
        last_wr = fl_wdata;
        cur_base = fl_addr;
      end
      if (fl_re) begin
        chk(fl_addr == cur_base, "R6 poll address", fl_addr, cur_base);
        chk(cyc - conf_cyc > PRE, "R5 pre-poll wait", cyc - conf_cyc, PRE + 1);
        reads++;
        fl_rdata = (reads >= ready_after) ? 8'h80 : 8'h00;
      end
    end
  end

  function automatic logic [31:0] sbase(input int i);
    return BASE + (32'(i) << 17);
  endfunction

  // driver: queue the expected writes, then pulse the request
  task automatic start_req(input int f, input int l, input bit tmo);
    for (int i = f; i <= l; i++) begin
      if (!protect[i]) begin
        exp_q.push_back({sbase(i), 8'h50});
        exp_q.push_back({sbase(i), 8'h20});
        exp_q.push_back({sbase(i), 8'hD0});
        if (tmo) begin
          exp_q.push_back({sbase(i), 8'hB0});
          exp_q.push_back({sbase(i), 8'hFF});
          break;
        end
        exp_q.push_back({sbase(i), 8'hFF});
      end
    end
    @(negedge clk);
    req_first = SIW'(f);
    req_last  = SIW'(l);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
  endtask

  task automatic wait_done(input bit e_err, input int e_skip, input string tag);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, {tag, " done seen"}, done, 1);
    chk(error == e_err, {tag, " error"}, error, e_err);
    chk(int'(skip_cnt) == e_skip, {tag, " skip_cnt"}, skip_cnt, e_skip);
    chk(exp_q.size() == 0, {tag, " all writes seen"}, exp_q.size(), 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R8 done pulse ends", {done, busy}, 0);
    exp_q.delete();
  endtask

  task automatic reject(input int f, input int l);
    @(negedge clk);
    req_first = SIW'(f);
    req_last  = SIW'(l);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(done && error && skip_cnt == 0, "R1 reject result", {done, error, skip_cnt}, 10'h300);
    @(negedge clk);
    chk(!done && !busy, "R1 reject returns idle", {done, busy}, 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_first = '0; req_last = '0;
    protect = '0; fl_rdata = 8'h00;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error && skip_cnt == 0 && !fl_we && !fl_re,
        "R8 reset state", {busy, done, error, skip_cnt, fl_we, fl_re}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: bad ranges, no bus traffic (monitor flags any write)
    reject(-1, 4);
    reject(5, 3);
    reject(-3, -2);

    // R2 R3 R4 R6: mixed range, one protected sector
    protect[3] = 1'b1;
    ready_after = 3;
    start_req(2, 5, 0);
    wait_done(0, 1, "R2 mixed range");

    // R2: every sector protected
    protect[12:10] = 3'b111;
    start_req(10, 12, 0);
    wait_done(0, 3, "R2 all protected");

    // R3: top sector address, ready on first read
    ready_after = 1;
    start_req(127, 127, 0);
    wait_done(0, 0, "R3 top sector");

    // R3: bottom sector at device base
    ready_after = 2;
    start_req(0, 0, 0);
    wait_done(0, 0, "R3 bottom sector");

    // R10: request while busy is ignored
    start_req(20, 21, 0);
    repeat (4) @(negedge clk);
    req_first = 8'sd0; req_last = 8'sd0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(0, 0, "R10 busy request");

    // R7: sector never ready, suspend and abort
    ready_after = 1000000;
    start_req(30, 32, 1);
    wait_done(1, 0, "R7 timeout");

    // R8: device usable after an abort
    ready_after = 1;
    start_req(40, 40, 0);
    wait_done(0, 0, "R8 after abort");

    finish_run();
  end
endmodule